// File: doc/BRIEF.md
# Partitioned Packed-Lane Integer Adder

This block is a 128-bit integer add/subtract datapath that treats each operand as a vector of independent lanes. A two-bit size code picks the lane width at run time: sixteen 8-bit lanes, eight 16-bit lanes, four 32-bit lanes or two 64-bit lanes. One add or subtract is applied to every lane in the same cycle. The carry chain is cut at each lane boundary that the size code selects, so no lane can disturb its neighbour.

Two modifiers change which data take part. Scalar form computes only the lowest lane and copies the first operand's remaining bits to the result. Broadcast form builds the second operand by replicating its low 64-bit element into both halves before the arithmetic. A strobe qualifies each request. The result and a valid flag are registered and appear one clock later.

Top module: `simd_lane_adder`

## Requirements
- R1: `lane_size` selects the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes, 2'b10 gives 32-bit lanes and 2'b11 gives 64-bit lanes. Lane 0 sits in the least significant bits, and lane k occupies bits [k*w +: w].
- R2: When `sub` is 0, each lane of `result` equals the sum of the matching lanes of `opa` and the second operand, modulo 2^w. No carry crosses a lane boundary.
- R3: When `sub` is 1, each lane of `result` equals the `opa` lane minus the second-operand lane, modulo 2^w. No borrow crosses a lane boundary.
- R4: When `scalar` is 1, only lane 0 is computed. Every bit above lane 0 in `result` equals the same bit of `opa`.
- R5: When `bcast` is 1, the second operand is {opb[63:0], opb[63:0]}, so `opb[127:64]` has no effect. When `bcast` is 0, the second operand is `opb`.
- R6: `out_valid` is 1 in the cycle after a cycle with `in_valid` = 1, and 0 in the cycle after a cycle with `in_valid` = 0. `result` carries the outcome of that request.
- R7: When `in_valid` is 0, `result` keeps its previous value, whatever the other inputs do.
- R8: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| opa | input | 128 | First operand vector |
| opb | input | 128 | Second operand vector |
| lane_size | input | 2 | Lane width code (00=8, 01=16, 10=32, 11=64 bits) |
| scalar | input | 1 | 1 = compute lane 0 only, pass the upper bits of opa |
| sub | input | 1 | 0 = add, 1 = subtract |
| bcast | input | 1 | 1 = replicate opb[63:0] into both halves of the second operand |
| out_valid | output | 1 | Result valid, one cycle after the strobe |
| result | output | 128 | Registered lane-wise result |

## Verification
The assertions assume that the operand, mode and strobe inputs are stable and known at each rising edge. Each per-lane arithmetic property compares against a plain wide add or subtract, and it only applies to the mode combination it names. The bench therefore changes inputs only on falling edges. It holds each request for exactly one cycle and follows every request with an idle or new request, so the hold and valid-timing properties see both strobe levels. The carry-boundary patterns use all-ones and zero lanes so that any leak across a lane would show up in the neighbouring lane.

// File: rtl/simd_lane_pkg.sv
package simd_lane_pkg;

    localparam int VEC_W   = 128;
    localparam int SLICE_W = 8;
    localparam int HALF_W  = VEC_W / 2;
    localparam int N_SLICE = VEC_W / SLICE_W;

    typedef enum logic [1:0] {
        LANE_W8  = 2'b00,
        LANE_W16 = 2'b01,
        LANE_W32 = 2'b10,
        LANE_W64 = 2'b11
    } lane_size_e;

    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] data;
    } out_state_t;

endpackage

// File: rtl/simd_operand_prep.sv
module simd_operand_prep #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W-1:0] opb,
    input  logic             bcast,
    input  logic             sub,
    output logic [VEC_W-1:0] b_eff
);
    localparam int HALF_W = VEC_W / 2;

    logic [VEC_W-1:0] b_sel_d;

    always_comb begin
        if (bcast) begin
            b_sel_d = {opb[HALF_W-1:0], opb[HALF_W-1:0]};
        end else begin
            b_sel_d = opb;
        end
        // subtract as a + ~b + 1; the +1 is injected at each lane start
        b_eff = sub ? ~b_sel_d : b_sel_d;
    end

endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder #(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 8
) (
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    input  logic [1:0]       lane_size,
    input  logic             seed,
    output logic [VEC_W-1:0] sum
);
    localparam int N_SLICE = VEC_W / SLICE_W;

    logic [N_SLICE-1:0] carry;

    assign carry[0] = 1'b0;

    for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
        logic lane_start;
        logic cin;

        always_comb begin
            int span;
            span = 1 << lane_size;
            lane_start = ((i % span) == 0);
            cin = lane_start ? seed : carry[i];
        end

        if (i == N_SLICE - 1) begin : g_top
            assign sum[i*SLICE_W +: SLICE_W] =
                a[i*SLICE_W +: SLICE_W] + b[i*SLICE_W +: SLICE_W]
                + {{(SLICE_W-1){1'b0}}, cin};
        end else begin : g_mid
            assign {carry[i+1], sum[i*SLICE_W +: SLICE_W]} =
                {1'b0, a[i*SLICE_W +: SLICE_W]} + {1'b0, b[i*SLICE_W +: SLICE_W]}
                + {{SLICE_W{1'b0}}, cin};
        end
    end

endmodule

// File: rtl/simd_scalar_merge.sv
module simd_scalar_merge #(
    parameter int VEC_W   = 128,
    parameter int SLICE_W = 8
) (
    input  logic [VEC_W-1:0] sum,
    input  logic [VEC_W-1:0] opa,
    input  logic [1:0]       lane_size,
    input  logic             scalar,
    output logic [VEC_W-1:0] merged
);
    localparam int N_SLICE = VEC_W / SLICE_W;

    for (genvar i = 0; i < N_SLICE; i++) begin : g_slice
        logic take_sum;

        always_comb begin
            int lane0_slices;
            lane0_slices = 1 << lane_size;
            take_sum = !scalar || (i < lane0_slices);
        end

        assign merged[i*SLICE_W +: SLICE_W] =
            take_sum ? sum[i*SLICE_W +: SLICE_W] : opa[i*SLICE_W +: SLICE_W];
    end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
    import simd_lane_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [127:0] opa,
    input  logic [127:0] opb,
    input  logic [1:0]   lane_size,
    input  logic         scalar,
    input  logic         sub,
    input  logic         bcast,
    output logic         out_valid,
    output logic [127:0] result
);
    logic [VEC_W-1:0] b_eff;
    logic [VEC_W-1:0] lane_sum;
    logic [VEC_W-1:0] merged;

    out_state_t state_d;
    out_state_t state_q;

    simd_operand_prep #(.VEC_W(VEC_W)) u_prep (
        .opb   (opb),
        .bcast (bcast),
        .sub   (sub),
        .b_eff (b_eff)
    );

    simd_seg_adder #(.VEC_W(VEC_W), .SLICE_W(SLICE_W)) u_add (
        .a         (opa),
        .b         (b_eff),
        .lane_size (lane_size),
        .seed      (sub),
        .sum       (lane_sum)
    );

    simd_scalar_merge #(.VEC_W(VEC_W), .SLICE_W(SLICE_W)) u_merge (
        .sum       (lane_sum),
        .opa       (opa),
        .lane_size (lane_size),
        .scalar    (scalar),
        .merged    (merged)
    );

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.data = merged;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign result    = state_q.data;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R6
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(result)); // R7
    AST_WIDE_ADD: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_size == LANE_W64 && !scalar && !sub && !bcast) |=>
        result == {$past(opa[127:64] + opb[127:64]), $past(opa[63:0] + opb[63:0])}); // R2
    AST_BYTE_SUB: assert property (@(posedge clk) disable iff (rst)
        (in_valid && lane_size == LANE_W8 && !scalar && sub && !bcast) |=>
        result[15:8] == $past(opa[15:8] - opb[15:8])); // R3
    AST_SCALAR_PASS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && scalar) |=> result[127:64] == $past(opa[127:64])); // R4
    AST_BCAST_HIGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bcast && lane_size == LANE_W64 && !scalar && !sub) |=>
        result[127:64] == $past(opa[127:64] + opb[63:0])); // R5

endmodule

// File: tb/simd_lane_adder_bench.sv
module simd_lane_adder_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic [1:0]   lane_size = 2'b00;
    logic         scalar = 1'b0;
    logic         sub = 1'b0;
    logic         bcast = 1'b0;
    logic         out_valid;
    logic [127:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    simd_lane_adder u_simd_lane_adder (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .opa       (opa),
        .opb       (opb),
        .lane_size (lane_size),
        .scalar    (scalar),
        .sub       (sub),
        .bcast     (bcast),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] code, input logic sc,
                                           input logic sb, input logic bc);
        logic [127:0] bb;
        logic [127:0] r;
        logic [63:0]  mask;
        int lw;
        bb = bc ? {b[63:0], b[63:0]} : b;
        lw = 8 << code;
        mask = (lw == 64) ? {64{1'b1}} : ((64'd1 << lw) - 64'd1);
        r = a;
        for (int k = 0; k < 128 / lw; k++) begin
            logic [63:0] x;
            logic [63:0] y;
            logic [63:0] z;
            if (!(sc && k > 0)) begin
                x = 64'((a >> (k * lw))) & mask;
                y = 64'((bb >> (k * lw))) & mask;
                z = (sb ? (x - y) : (x + y)) & mask;
                r = (r & ~({64'd0, mask} << (k * lw))) | ({64'd0, z} << (k * lw));
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // drive one request at a falling edge, sample at the next falling edge
    task automatic run_op(input string tag, input logic [127:0] a, input logic [127:0] b,
                          input logic [1:0] code, input logic sc, input logic sb,
                          input logic bc);
        @(negedge clk);
        opa = a; opb = b; lane_size = code; scalar = sc; sub = sb; bcast = bc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(tag, result, model(a, b, code, sc, sb, bc));
        check({tag, " valid"}, {127'd0, out_valid}, 128'd1);
    endtask

    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b1; opa = '1; opb = '1;
        @(negedge clk);
        @(negedge clk);
        check("R8 reset result", result, '0);
        check("R8 reset valid", {127'd0, out_valid}, '0);
        rst = 1'b0; in_valid = 1'b0;
    endtask

    task automatic test_lane_widths();
        // all-ones plus one: wraps to zero inside each lane of the chosen width
        for (int c = 0; c < 4; c++) begin
            logic [127:0] one_per_lane;
            one_per_lane = '0;
            for (int k = 0; k < 128 / (8 << c); k++) one_per_lane[k * (8 << c)] = 1'b1;
            run_op("R1 R2 lane wrap", '1, one_per_lane, 2'(c), 1'b0, 1'b0, 1'b0);
        end
        run_op("R1 lane0 placement", 128'h0, 128'h0000_0000_0000_0005_0000_0000_0000_0003,
               2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_packed_add();
        for (int c = 0; c < 4; c++) begin
            run_op("R2 packed add", {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom}, 2'(c), 1'b0, 1'b0, 1'b0);
        end
    endtask

    task automatic test_packed_sub();
        for (int c = 0; c < 4; c++) begin
            run_op("R3 borrow stop", '0, 128'h1, 2'(c), 1'b0, 1'b1, 1'b0);
            run_op("R3 packed sub", {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom}, 2'(c), 1'b0, 1'b1, 1'b0);
        end
    endtask

    task automatic test_scalar();
        for (int c = 0; c < 4; c++) begin
            run_op("R4 scalar add", 128'hDEAD_BEEF_0123_4567_89AB_CDEF_FFFF_FFFF,
                   '1, 2'(c), 1'b1, 1'b0, 1'b0);
            run_op("R4 scalar sub", {$urandom, $urandom, $urandom, $urandom},
                   {$urandom, $urandom, $urandom, $urandom}, 2'(c), 1'b1, 1'b1, 1'b0);
        end
    endtask

    task automatic test_bcast();
        run_op("R5 bcast add", 128'h1111_2222_3333_4444_5555_6666_7777_8888,
               128'hFFFF_FFFF_FFFF_FFFF_0000_0000_0000_0010, 2'b11, 1'b0, 1'b0, 1'b1);
        run_op("R5 bcast sub bytes", {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, 2'b00, 1'b0, 1'b1, 1'b1);
        run_op("R5 no bcast", 128'h0, 128'hAAAA_0000_0000_0000_0000_0000_0000_0001,
               2'b11, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic test_timing_hold();
        logic [127:0] held;
        run_op("R6 op", 128'h5, 128'h7, 2'b10, 1'b0, 1'b0, 1'b0);
        held = result;
        @(negedge clk);
        opa = '1; opb = '1; sub = 1'b1; bcast = 1'b1; lane_size = 2'b00;
        @(negedge clk);
        check("R6 valid drops", {127'd0, out_valid}, '0);
        check("R7 idle hold", result, held);
        @(negedge clk);
        check("R7 idle hold 2", result, held);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (2) @(negedge clk);
        test_reset();
        test_lane_widths();
        test_packed_add();
        test_packed_sub();
        test_scalar();
        test_bcast();
        test_timing_hold();
        test_reset();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule